// File: doc/BRIEF.md
# Sleep Mode Power Sequencer

This block is the power manager's state machine for sleep. On a sleep request it shuts the chip down in a fixed order. It first asks the peripheral logic to stop. Once the peripherals report idle, it asks the SDRAM controller to enter self-refresh. Once that is acknowledged, it freezes the pins at their programmed levels. Only then does it go to sleep. While asleep, only wake-up detection and a free-running always-on timer keep working.

A configuration bit is sampled when the sleep request is accepted, and it selects one of two options. In the low-power option the power-enable output is dropped so that the external core and PLL regulators can be switched off. On wake, power-enable is raised again and a programmable stabilisation delay runs before anything else happens. In the low-latency option power-enable stays high for the whole sleep and the stabilisation delay is skipped.

Every exit from sleep ends in a core reset of fixed minimum length, so the core restarts in boot mode rather than resuming. A sticky flag then tells boot code that the reset came from a sleep exit. A wake-up event that arrives while the shutdown is still in progress is remembered and acted on as soon as the asleep state is reached.

Top module: `slp_pwr_seq`

## Requirements
- R1: Shutdown order is fixed. `periph_stop_o` rises first. `sr_req_o` rises only on the cycle after the edge at which `periph_idle_i` is sampled high. `pin_hold_o` rises only on the cycle after the edge at which `sr_ack_i` is sampled high. The asleep state follows one cycle after `pin_hold_o` rises.
- R2: If `low_lat_i` was 0 when `sleep_req_i` was accepted, `pwr_en_o` is 0 while asleep. A later change of `low_lat_i` during sleep has no effect on `pwr_en_o`.
- R3: If `low_lat_i` was 1 when the request was accepted, `pwr_en_o` stays 1 throughout. `core_rst_o` rises on the cycle after the edge that samples the wake-up event, with no stabilisation delay.
- R4: In the low-power option, a wake-up event first raises `pwr_en_o`. `core_rst_o` then rises after exactly `stab_cycles_i`+1 cycles with power-enable high. `stab_cycles_i` is sampled at the wake edge.
- R5: `sr_req_o` and `pin_hold_o`, once raised during entry, stay at 1 until the core reset ends. `pwr_en_o` is only ever 0 while both are 1.
- R6: A wake-up event sampled during the shutdown sequence is latched. The exit starts on the edge right after the asleep state is reached, without a further event.
- R7: `core_rst_o` is held at 1 for exactly RST_CYC cycles (default 4). It is only asserted while `pin_hold_o` is 1. After it falls, all sleep outputs return to their run values.
- R8: `boot_from_sleep_o` becomes 1 with the sleep-exit reset and stays 1 until the synchronous reset `rst`.
- R9: `wake_evt_i` has no effect in the run state. `sleep_req_i` has no effect while asleep.
- R10: `aon_count_o` increments by one every cycle, asleep included, and is cleared only by `rst`.
- R11: After `rst`, the outputs are in the run state. `pwr_en_o` is 1. `periph_stop_o`, `sr_req_o`, `pin_hold_o`, `core_rst_o`, `boot_from_sleep_o` and `aon_count_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req_i | input | 1 | Request to enter sleep (acted on in run state) |
| wake_evt_i | input | 1 | Wake-up event |
| low_lat_i | input | 1 | 1 = keep supplies on and skip stabilisation, 0 = drop power |
| stab_cycles_i | input | SW (8) | Stabilisation delay length after power-enable returns |
| periph_idle_i | input | 1 | Peripheral shutdown logic reports idle |
| sr_ack_i | input | 1 | SDRAM controller acknowledges self-refresh |
| pwr_en_o | output | 1 | Enable for external core/PLL supplies |
| periph_stop_o | output | 1 | Request to peripherals to stop |
| sr_req_o | output | 1 | SDRAM self-refresh request |
| pin_hold_o | output | 1 | Hold pins at programmed levels |
| core_rst_o | output | 1 | Reset request to the core |
| boot_from_sleep_o | output | 1 | Sticky flag: last core reset was a sleep exit |
| aon_count_o | output | AW (32) | Always-on free-running timer |

## Verification
The hardest case to reach is a wake-up event that lands while the shutdown handshakes are still running. The event must be remembered across the pin-freeze step and must start the exit with no second event. The stimulus gets there by pulsing the wake input in the cycle just after the sleep request, with both acknowledges already high. It then counts the cycles to the core reset: three shutdown edges, plus the stabilisation window when power was dropped. A second hard case is holding a handshake low to stall the sequence mid-way. The bench freezes the peripheral-idle input and then the self-refresh acknowledge, and checks that no later step starts early.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_STOP   = 3'd1,
        ST_SREF   = 3'd2,
        ST_HOLD   = 3'd3,
        ST_ASLEEP = 3'd4,
        ST_PWRUP  = 3'd5,
        ST_RESET  = 3'd6
    } slp_state_e;

    typedef struct packed {
        logic pwr_en;
        logic periph_stop;
        logic sr_req;
        logic pin_hold;
        logic core_rst;
    } slp_out_t;

    function automatic slp_out_t slp_decode(slp_state_e st, logic lowlat);
        slp_out_t o;
        o.pwr_en      = !((st == ST_ASLEEP) && !lowlat);
        o.periph_stop = (st != ST_RUN);
        o.sr_req      = (st == ST_SREF) || (st == ST_HOLD) || (st == ST_ASLEEP) ||
                        (st == ST_PWRUP) || (st == ST_RESET);
        o.pin_hold    = (st == ST_HOLD) || (st == ST_ASLEEP) ||
                        (st == ST_PWRUP) || (st == ST_RESET);
        o.core_rst    = (st == ST_RESET);
        return o;
    endfunction

endpackage

// File: rtl/slp_down_cnt.sv
module slp_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/slp_aon_timer.sv
module slp_aon_timer #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    // R10: the timer advances every cycle, asleep or not
    a_r10_aon_steps: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       wake_evt,
    input  logic       low_lat,
    input  logic       periph_idle,
    input  logic       sr_ack,
    input  logic       stab_zero,
    input  logic       rcnt_zero,
    output slp_state_e state,
    output logic       lowlat_q,
    output logic       stab_load,
    output logic       stab_dec,
    output logic       rcnt_load,
    output logic       rcnt_dec,
    output logic       boot_flag
);
    slp_state_e nxt;
    logic       wake_pend;
    logic       in_entry;

    assign in_entry = (state == ST_STOP) || (state == ST_SREF) || (state == ST_HOLD);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (sleep_req)   nxt = ST_STOP;
            ST_STOP:   if (periph_idle) nxt = ST_SREF;
            ST_SREF:   if (sr_ack)      nxt = ST_HOLD;
            ST_HOLD:                    nxt = ST_ASLEEP;
            ST_ASLEEP: if (wake_evt || wake_pend)
                           nxt = lowlat_q ? ST_RESET : ST_PWRUP;
            ST_PWRUP:  if (stab_zero)   nxt = ST_RESET;
            ST_RESET:  if (rcnt_zero)   nxt = ST_RUN;
            default:                    nxt = ST_RUN;
        endcase
    end

    assign stab_load = (state == ST_ASLEEP) && (nxt == ST_PWRUP);
    assign stab_dec  = (state == ST_PWRUP);
    assign rcnt_load = (state != ST_RESET) && (nxt == ST_RESET);
    assign rcnt_dec  = (state == ST_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            lowlat_q  <= 1'b0;
            wake_pend <= 1'b0;
            boot_flag <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && sleep_req) lowlat_q <= low_lat;
            if (in_entry && wake_evt)         wake_pend <= 1'b1;
            else if (state == ST_ASLEEP)      wake_pend <= 1'b0;
            if (rcnt_load)                    boot_flag <= 1'b1;
        end
    end

    // R6: a latched early wake never survives the asleep state
    a_r6_pend_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(state == ST_ASLEEP) && state != ST_ASLEEP |-> !wake_pend);

    // R9: a wake event while running never starts the shutdown
    a_r9_run_wake_ignored: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN && !sleep_req |=> state == ST_RUN);
endmodule

// File: rtl/slp_pwr_seq.sv
module slp_pwr_seq
    import slp_pkg::*;
#(
    parameter int SW      = 8,
    parameter int AW      = 32,
    parameter int RST_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_req_i,
    input  logic          wake_evt_i,
    input  logic          low_lat_i,
    input  logic [SW-1:0] stab_cycles_i,
    input  logic          periph_idle_i,
    input  logic          sr_ack_i,
    output logic          pwr_en_o,
    output logic          periph_stop_o,
    output logic          sr_req_o,
    output logic          pin_hold_o,
    output logic          core_rst_o,
    output logic          boot_from_sleep_o,
    output logic [AW-1:0] aon_count_o
);
    localparam int RW = (RST_CYC < 2) ? 1 : $clog2(RST_CYC);
    localparam logic [RW-1:0] RLOAD = RW'(RST_CYC - 1);

    slp_state_e state;
    slp_out_t   outs;
    logic       lowlat_q;
    logic       stab_load, stab_dec, stab_zero;
    logic       rcnt_load, rcnt_dec, rcnt_zero;

    slp_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_req   (sleep_req_i),
        .wake_evt    (wake_evt_i),
        .low_lat     (low_lat_i),
        .periph_idle (periph_idle_i),
        .sr_ack      (sr_ack_i),
        .stab_zero   (stab_zero),
        .rcnt_zero   (rcnt_zero),
        .state       (state),
        .lowlat_q    (lowlat_q),
        .stab_load   (stab_load),
        .stab_dec    (stab_dec),
        .rcnt_load   (rcnt_load),
        .rcnt_dec    (rcnt_dec),
        .boot_flag   (boot_from_sleep_o)
    );

    slp_down_cnt #(.W(SW)) u_stab (
        .clk      (clk),
        .rst      (rst),
        .load     (stab_load),
        .load_val (stab_cycles_i),
        .dec      (stab_dec),
        .zero     (stab_zero)
    );

    slp_down_cnt #(.W(RW)) u_rhold (
        .clk      (clk),
        .rst      (rst),
        .load     (rcnt_load),
        .load_val (RLOAD),
        .dec      (rcnt_dec),
        .zero     (rcnt_zero)
    );

    slp_aon_timer #(.AW(AW)) u_aon (
        .clk   (clk),
        .rst   (rst),
        .count (aon_count_o)
    );

    assign outs          = slp_decode(state, lowlat_q);
    assign pwr_en_o      = outs.pwr_en;
    assign periph_stop_o = outs.periph_stop;
    assign sr_req_o      = outs.sr_req;
    assign pin_hold_o    = outs.pin_hold;
    assign core_rst_o    = outs.core_rst;

    // R1: self-refresh is requested only after the peripherals reported idle
    a_r1_sref_after_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_req_o) |-> $past(periph_idle_i));

    // R5: supplies are only ever off with SDRAM in self-refresh and pins held
    a_r5_power_off_guarded: assert property (@(posedge clk) disable iff (rst)
        !pwr_en_o |-> sr_req_o && pin_hold_o);

    // R7: core reset only while the pins are frozen
    a_r7_rst_under_hold: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> pin_hold_o && periph_stop_o);

    // R4: in the low-power option the core reset is preceded by restored power
    a_r4_power_before_rst: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_o) && !lowlat_q |-> $past(pwr_en_o));
endmodule

// File: tb/sim_slp_pwr_seq.sv
module sim_slp_pwr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_req = 1'b0, wake_evt = 1'b0, low_lat = 1'b0;
    logic [7:0]  stab = 8'd0;
    logic        periph_idle = 1'b1, sr_ack = 1'b1;
    logic        pwr_en, periph_stop, sr_req, pin_hold, core_rst, boot_flag;
    logic [31:0] aon;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam int RSTC = 4;
    // {early wake, low_lat, stab_cycles, expected cycles from wake to core reset}
    localparam int NV = 5;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'd3, 8'd4},
        {1'b0, 1'b1, 8'd5, 8'd0},
        {1'b1, 1'b0, 8'd0, 8'd4},
        {1'b1, 1'b1, 8'd2, 8'd3},
        {1'b0, 1'b0, 8'd7, 8'd8}
    };

    always #5 clk = ~clk;

    slp_pwr_seq u0 (
        .clk(clk), .rst(rst), .sleep_req_i(sleep_req), .wake_evt_i(wake_evt),
        .low_lat_i(low_lat), .stab_cycles_i(stab), .periph_idle_i(periph_idle),
        .sr_ack_i(sr_ack), .pwr_en_o(pwr_en), .periph_stop_o(periph_stop),
        .sr_req_o(sr_req), .pin_hold_o(pin_hold), .core_rst_o(core_rst),
        .boot_from_sleep_o(boot_flag), .aon_count_o(aon)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // counts cycles until core_rst rises, then checks its width and the release state
    task automatic finish_exit(input int exp_gap, input string tag);
        int k = 0;
        int w = 0;
        while (!core_rst && k < 400) begin @(negedge clk); k++; end
        chk({tag, " R4 wake-to-reset gap"}, k, exp_gap);
        while (core_rst && w < 50) begin @(negedge clk); w++; end
        chk("R7 core reset width", w, RSTC);
        chk("R7 released", {pwr_en, periph_stop, sr_req, pin_hold}, 4'b1000);
        chk("R8 boot flag", boot_flag, 1'b1);
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state (one edge after release: aon = 1)
        chk("R11 outputs", {pwr_en, periph_stop, sr_req, pin_hold, core_rst, boot_flag}, 6'b100000);
        chk("R11 aon", aon, 32'd1);

        // R9: wake in run ignored
        wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 wake in run", {periph_stop, core_rst}, 2'b00);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic e, ll;
            logic [7:0] sc, gap;
            {e, ll, sc, gap} = VEC[v];
            low_lat = ll; stab = sc; sleep_req = 1'b1;
            @(negedge clk); sleep_req = 1'b0;
            chk("R1 stop first", {periph_stop, sr_req}, 2'b10);
            if (e) begin
                wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;   // R6 early wake
                finish_exit(gap, "R6");
            end else begin
                repeat (5) @(negedge clk);
                chk("R2/R3 pwr_en asleep", pwr_en, ll);
                chk("R5 held asleep", {sr_req, pin_hold}, 2'b11);
                low_lat = ~ll; @(negedge clk);
                chk("R2 option latched", pwr_en, ll);
                wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
                chk("R4 power restored", pwr_en, 1'b1);
                finish_exit(gap, ll ? "R3" : "R4");
            end
            repeat (2) @(negedge clk);
        end

        // R1 ordering with stalled handshakes
        periph_idle = 1'b0; sr_ack = 1'b0; low_lat = 1'b0; stab = 8'd1;
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 no sref before idle", {periph_stop, sr_req, pin_hold, pwr_en}, 4'b1001);
        periph_idle = 1'b1; @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 no hold before ack", {sr_req, pin_hold, pwr_en}, 3'b101);
        sr_ack = 1'b1; @(negedge clk);
        chk("R1 hold after ack", pin_hold, 1'b1);
        @(negedge clk);
        chk("R2 asleep power off", pwr_en, 1'b0);

        // R9 sleep_req while asleep ignored, R10 aon runs during sleep
        begin
            logic [31:0] a0;
            a0 = aon;
            sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
            repeat (4) @(negedge clk);
            chk("R10 aon asleep", aon - a0, 32'd5);
            chk("R9 sleep_req asleep", {pwr_en, core_rst, pin_hold}, 3'b001);
        end
        wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
        finish_exit(2, "R4");

        // R8 flag cleared only by rst
        chk("R8 flag sticky", boot_flag, 1'b1);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        chk("R8 flag cleared", boot_flag, 1'b0);
        chk("R11 aon after rst", aon, 32'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule